// File: doc/BRIEF.md
# Half-Bridge Gate Interlock with Dead Time

This block sits between a PWM source and the two gate drivers of one half-bridge leg. It takes an in-phase high-side command and an active-low low-side command, and produces the two gate enables. It blocks the case where both switches conduct at once, keeps a minimum dead time between one switch turning off and the other turning on, and removes drive when a supply is not healthy. After a negative switch-node transient it also holds the high-side switch off for a fixed time.

All timing is counted in clock cycles. `DT_CYCLES` sets the minimum dead time. Its default of 53 cycles gives 530 ns at 100 MHz. `HOLD_CYCLES` sets the transient hold-off. Its default of 450 cycles gives 4.5 us at 100 MHz. Both command paths pass through the same two registers, so the high-side and low-side channels have the same delay. A gap between commands that is already at least the minimum dead time reaches the outputs unchanged. A shorter gap is stretched to exactly the minimum.

Top module: `hb_gate_guard`

## Requirements
- R1: `hi_en` follows `hi_cmd` (1 = on) two clock edges after the input, while the low side is not commanded, both supply flags are 1 and no hold-off is running.
- R2: `lo_en` is 1 two clock edges after `lo_cmd_n` is 0, while the high side is not commanded and `logic_ok` is 1. The delay is the same as the high-side delay.
- R3: `hi_en` and `lo_en` are never 1 in the same cycle.
- R4: When `hi_cmd` is 1 and `lo_cmd_n` is 0 together, both outputs are 0 two edges later.
- R5: After `lo_en` falls, `hi_en` stays 0 for at least `DT_CYCLES` cycles. If the high side is commanded sooner, `hi_en` rises exactly `DT_CYCLES` cycles after `lo_en` fell.
- R6: After `hi_en` falls, `lo_en` stays 0 for at least `DT_CYCLES` cycles. The low side is stretched the same way, so both handovers get the same dead time.
- R7: When the external gap between one command ending and the other starting is `DT_CYCLES` or more, each output edge comes exactly two edges after its input edge, and the gap is kept.
- R8: While `logic_ok` is 0, both outputs are 0 two edges later. This includes power-up, before the flag first becomes 1.
- R9: While `float_ok` is 0, `hi_en` is 0 two edges later. `lo_en` is not affected.
- R10: A one-cycle pulse on `neg_evt` forces `hi_en` to 0 for exactly `HOLD_CYCLES` cycles, starting two edges after the pulse. `lo_en` is not affected.
- R11: A new `neg_evt` pulse during a running hold-off restarts the full `HOLD_CYCLES` count from that pulse.
- R12: Synchronous reset (`rst` = 1) drives both outputs to 0 and clears the dead-time and hold-off state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| hi_cmd | input | 1 | High-side command, 1 = switch on |
| lo_cmd_n | input | 1 | Low-side command, 0 = switch on |
| logic_ok | input | 1 | Logic supply above its undervoltage threshold |
| float_ok | input | 1 | Floating high-side supply above its undervoltage threshold |
| neg_evt | input | 1 | Negative switch-node transient detected |
| hi_en | output | 1 | High-side gate enable |
| lo_en | output | 1 | Low-side gate enable |

## Verification
The commands are driven with several handover patterns:
- An immediate swap in each direction shows that the dead time is inserted symmetrically.
- A short external gap of two cycles shows that a gap shorter than the minimum is stretched to exactly `DT_CYCLES`.
- A gap longer than the minimum shows that timing passes through untouched.
- Overlapping commands separate the both-off interlock from the dead-time logic.

Supply-flag drops, single transient pulses and retriggered pulses, each applied while the high side is commanded, show which outputs each protection path can reach and how long the hold-off lasts.

// File: rtl/hb_pkg.sv
`timescale 1ns/1ps
package hb_pkg;

    localparam int unsigned DT_DEFAULT   = 53;
    localparam int unsigned HOLD_DEFAULT = 450;

    typedef enum logic [1:0] {
        SIDE_NONE = 2'd0,
        SIDE_HI   = 2'd1,
        SIDE_LO   = 2'd2
    } side_e;

    // Sampled command word, both polarities normalised to active high
    typedef struct packed {
        logic hi_req;
        logic lo_req;
        logic logic_ok;
        logic float_ok;
        logic neg_evt;
    } cmd_s;

    typedef struct packed {
        logic hi;
        logic lo;
    } gate_s;

    // Cross-conduction filter: a conflicting request switches both off
    function automatic gate_s interlock(cmd_s c);
        gate_s g;
        g.hi = c.hi_req & ~c.lo_req;
        g.lo = c.lo_req & ~c.hi_req;
        return g;
    endfunction

endpackage

// File: rtl/hb_sample.sv
`timescale 1ns/1ps
module hb_sample
    import hb_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic hi_cmd,
    input  logic lo_cmd_n,
    input  logic logic_ok,
    input  logic float_ok,
    input  logic neg_evt,
    output cmd_s cmd_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            cmd_q <= '0;
        end else begin
            cmd_q.hi_req   <= hi_cmd;
            cmd_q.lo_req   <= ~lo_cmd_n;
            cmd_q.logic_ok <= logic_ok;
            cmd_q.float_ok <= float_ok;
            cmd_q.neg_evt  <= neg_evt;
        end
    end

endmodule

// File: rtl/hb_holdoff.sv
`timescale 1ns/1ps
module hb_holdoff #(
    parameter int unsigned HOLD_CYCLES = hb_pkg::HOLD_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    output logic block
);

    localparam int unsigned HW = $clog2(HOLD_CYCLES + 1);
    localparam logic [HW-1:0] RELOAD = HW'(HOLD_CYCLES - 1);

    logic [HW-1:0] remain;

    // The trigger cycle itself blocks, then RELOAD more cycles follow
    assign block = trig | (remain != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            remain <= '0;
        end else if (trig) begin
            remain <= RELOAD;
        end else if (remain != '0) begin
            remain <= remain - 1'b1;
        end
    end

endmodule

// File: rtl/hb_deadband.sv
`timescale 1ns/1ps
module hb_deadband
    import hb_pkg::*;
#(
    parameter int unsigned DT_CYCLES = hb_pkg::DT_DEFAULT
) (
    input  logic  clk,
    input  logic  rst,
    input  gate_s want,
    input  logic  hi_allow,
    input  logic  lo_allow,
    output gate_s en
);

    localparam int unsigned DT_LAST = DT_CYCLES - 1;
    localparam int unsigned GW      = (DT_CYCLES > 2) ? $clog2(DT_CYCLES) : 1;

    logic [GW-1:0] gap;
    side_e         last;
    logic          gap_done;
    logic          ok_hi;
    logic          ok_lo;
    gate_s         nxt;

    always_comb begin
        gap_done = (gap == GW'(DT_LAST));
        ok_hi    = ~en.lo & ((last != SIDE_LO) | gap_done);
        ok_lo    = ~en.hi & ((last != SIDE_HI) | gap_done);
        nxt.hi   = want.hi & hi_allow & ok_hi;
        nxt.lo   = want.lo & lo_allow & ok_lo;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            en   <= '0;
            gap  <= '0;
            last <= SIDE_NONE;
        end else begin
            en <= nxt;
            if (en.hi | en.lo) begin
                gap <= '0;
            end else if (!gap_done) begin
                gap <= gap + 1'b1;
            end
            if (nxt.hi) begin
                last <= SIDE_HI;
            end else if (nxt.lo) begin
                last <= SIDE_LO;
            end
        end
    end

endmodule

// File: rtl/hb_gate_guard.sv
`timescale 1ns/1ps
module hb_gate_guard
    import hb_pkg::*;
#(
    parameter int unsigned DT_CYCLES   = hb_pkg::DT_DEFAULT,
    parameter int unsigned HOLD_CYCLES = hb_pkg::HOLD_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic hi_cmd,
    input  logic lo_cmd_n,
    input  logic logic_ok,
    input  logic float_ok,
    input  logic neg_evt,
    output logic hi_en,
    output logic lo_en
);

    cmd_s  cmd_q;
    gate_s want;
    gate_s en;
    logic  hold_blk;
    logic  hi_allow;
    logic  lo_allow;

    hb_sample u_sample (
        .clk      (clk),
        .rst      (rst),
        .hi_cmd   (hi_cmd),
        .lo_cmd_n (lo_cmd_n),
        .logic_ok (logic_ok),
        .float_ok (float_ok),
        .neg_evt  (neg_evt),
        .cmd_q    (cmd_q)
    );

    hb_holdoff #(.HOLD_CYCLES(HOLD_CYCLES)) u_hold (
        .clk   (clk),
        .rst   (rst),
        .trig  (cmd_q.neg_evt),
        .block (hold_blk)
    );

    // The logic supply gates both channels, the floating supply and the hold-off only the high side
    always_comb begin
        want     = interlock(cmd_q);
        lo_allow = cmd_q.logic_ok;
        hi_allow = cmd_q.logic_ok & cmd_q.float_ok & ~hold_blk;
    end

    hb_deadband #(.DT_CYCLES(DT_CYCLES)) u_dead (
        .clk      (clk),
        .rst      (rst),
        .want     (want),
        .hi_allow (hi_allow),
        .lo_allow (lo_allow),
        .en       (en)
    );

    assign hi_en = en.hi;
    assign lo_en = en.lo;

endmodule

// File: rtl/hb_gate_guard_chk.sv
`timescale 1ns/1ps
module hb_gate_guard_chk #(
    parameter int unsigned DT_CYCLES   = hb_pkg::DT_DEFAULT,
    parameter int unsigned HOLD_CYCLES = hb_pkg::HOLD_DEFAULT
) (
    input logic clk,
    input logic rst,
    input logic hi_cmd,
    input logic lo_cmd_n,
    input logic logic_ok,
    input logic float_ok,
    input logic neg_evt,
    input logic hi_en,
    input logic lo_en
);

    localparam int unsigned GW = $clog2(DT_CYCLES + 1);
    localparam int unsigned CW = $clog2(HOLD_CYCLES + 1);

    logic [1:0]    cyc;
    logic [GW-1:0] off_run;
    logic          was_lo;
    logic          was_hi;
    logic          evt_d;
    logic [CW-1:0] hold_left;

    always_ff @(posedge clk) begin
        if (rst) begin
            cyc       <= '0;
            off_run   <= '0;
            was_lo    <= 1'b0;
            was_hi    <= 1'b0;
            evt_d     <= 1'b0;
            hold_left <= '0;
        end else begin
            if (cyc != 2'd2) cyc <= cyc + 1'b1;
            if (hi_en | lo_en) off_run <= '0;
            else if (off_run != GW'(DT_CYCLES)) off_run <= off_run + 1'b1;
            if (lo_en) begin
                was_lo <= 1'b1;
                was_hi <= 1'b0;
            end else if (hi_en) begin
                was_hi <= 1'b1;
                was_lo <= 1'b0;
            end
            evt_d <= neg_evt;
            if (evt_d) hold_left <= CW'(HOLD_CYCLES);
            else if (hold_left != '0) hold_left <= hold_left - 1'b1;
        end
    end

    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(hi_en && lo_en)); // R3

    AST_HI_ROSE_CMD: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd2 && $rose(hi_en)) |-> ($past(hi_cmd, 2) && $past(lo_cmd_n, 2))); // R1

    AST_LO_ROSE_CMD: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd2 && $rose(lo_en)) |-> (!$past(lo_cmd_n, 2) && !$past(hi_cmd, 2))); // R2

    AST_CONFLICT_OFF: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd2 && $past(hi_cmd, 2) && !$past(lo_cmd_n, 2)) |-> (!hi_en && !lo_en)); // R4

    AST_DEAD_LO_HI: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd2 && $rose(hi_en) && was_lo) |-> (off_run >= GW'(DT_CYCLES))); // R5

    AST_DEAD_HI_LO: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd2 && $rose(lo_en) && was_hi) |-> (off_run >= GW'(DT_CYCLES))); // R6

    AST_LOGIC_LOCK: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd2 && !$past(logic_ok, 2)) |-> (!hi_en && !lo_en)); // R8

    AST_FLOAT_LOCK: assert property (@(posedge clk) disable iff (rst)
        (cyc == 2'd2 && !$past(float_ok, 2)) |-> !hi_en); // R9

    AST_HOLD_WINDOW: assert property (@(posedge clk) disable iff (rst)
        (hold_left != '0) |-> !hi_en); // R10 R11

endmodule

bind hb_gate_guard hb_gate_guard_chk #(
    .DT_CYCLES   (DT_CYCLES),
    .HOLD_CYCLES (HOLD_CYCLES)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .hi_cmd   (hi_cmd),
    .lo_cmd_n (lo_cmd_n),
    .logic_ok (logic_ok),
    .float_ok (float_ok),
    .neg_evt  (neg_evt),
    .hi_en    (hi_en),
    .lo_en    (lo_en)
);

// File: tb/hb_gate_guard_test.sv
`timescale 1ns/1ps
module hb_gate_guard_test;

    localparam int DT   = 4;
    localparam int HOLD = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic hi_cmd = 1'b0;
    logic lo_cmd_n = 1'b1;
    logic logic_ok = 1'b0;
    logic float_ok = 1'b0;
    logic neg_evt = 1'b0;
    logic hi_en;
    logic lo_en;

    always #2.5 clk = ~clk;

    hb_gate_guard #(.DT_CYCLES(DT), .HOLD_CYCLES(HOLD)) uut (
        .clk      (clk),
        .rst      (rst),
        .hi_cmd   (hi_cmd),
        .lo_cmd_n (lo_cmd_n),
        .logic_ok (logic_ok),
        .float_ok (float_ok),
        .neg_evt  (neg_evt),
        .hi_en    (hi_en),
        .lo_en    (lo_en)
    );

    int    compared = 0;
    int    mismatched = 0;
    int    cyc = 0;
    bit    done = 1'b0;

    int    q_due[$];
    bit    q_hi[$];
    bit    q_lo[$];
    string q_tag[$];

    // Reference state taken from the requirements
    bit m_hi = 1'b0;
    bit m_lo = 1'b0;
    int m_gap = 0;
    int m_last = 0;   // 0 none, 1 high side, 2 low side
    int m_hold = 0;

    task automatic drive(input bit h, input bit ln, input bit lok, input bit fok,
                         input bit ev, input int n, input string tag);
        for (int i = 0; i < n; i++) begin
            bit lr;
            bit evn;
            bit blk;
            bit ph;
            bit pl;
            bit nh;
            bit nl;
            @(negedge clk);
            evn      = ev && (i == 0);
            hi_cmd   = h;
            lo_cmd_n = ln;
            logic_ok = lok;
            float_ok = fok;
            neg_evt  = evn;
            lr  = !ln;
            blk = evn || (m_hold > 0);
            m_hold = evn ? HOLD - 1 : ((m_hold > 0) ? m_hold - 1 : 0);
            ph = !m_lo && (m_last != 2 || m_gap >= DT);
            pl = !m_hi && (m_last != 1 || m_gap >= DT);
            nh = lok && fok && !blk && h && !lr && ph;
            nl = lok && lr && !h && pl;
            m_gap = (nh || nl) ? 0 : ((m_gap < 1000) ? m_gap + 1 : m_gap);
            if (nh) m_last = 1;
            else if (nl) m_last = 2;
            m_hi = nh;
            m_lo = nl;
            q_due.push_back(cyc + 2);
            q_hi.push_back(nh);
            q_lo.push_back(nl);
            q_tag.push_back(tag);
        end
    endtask

    // Monitor: pops each expected item in the cycle it falls due
    initial begin
        forever begin
            @(posedge clk);
            #1;
            cyc++;
            if (!rst) begin
                compared++;
                if (hi_en === 1'b1 && lo_en === 1'b1) begin
                    mismatched++;
                    $display("FAIL R3 overlap: hi_en/lo_en = %b%b, expected not 11", hi_en, lo_en);
                end
            end
            while (q_due.size() > 0 && q_due[0] == cyc) begin
                compared++;
                if (hi_en !== q_hi[0] || lo_en !== q_lo[0]) begin
                    mismatched++;
                    $display("FAIL %s (cycle %0d): hi_en/lo_en = %b%b, expected %b%b",
                             q_tag[0], cyc, hi_en, lo_en, q_hi[0], q_lo[0]);
                end
                void'(q_due.pop_front());
                void'(q_hi.pop_front());
                void'(q_lo.pop_front());
                void'(q_tag.pop_front());
            end
        end
    end

    initial begin
        #200000;
        if (!done) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        compared++;
        if (hi_en !== 1'b0 || lo_en !== 1'b0) begin
            mismatched++;
            $display("FAIL R12 reset state: hi_en/lo_en = %b%b, expected 00", hi_en, lo_en);
        end
        @(negedge clk);
        rst = 1'b0;

        drive(1, 1, 0, 0, 0, 4, "R8 power-up with logic supply low");
        drive(0, 1, 1, 1, 0, 3, "R1 idle");
        drive(1, 1, 1, 1, 0, 6, "R1 high side on");
        drive(0, 1, 1, 1, 0, 6, "R7 long external gap");
        drive(0, 0, 1, 1, 0, 6, "R2 low side on after long gap");
        drive(1, 1, 1, 1, 0, 8, "R5 immediate swap to high side");
        drive(0, 0, 1, 1, 0, 8, "R6 immediate swap to low side");
        drive(1, 0, 1, 1, 0, 4, "R4 both commanded");
        drive(1, 1, 1, 1, 0, 8, "R5 high side after overlap");
        drive(0, 0, 1, 1, 0, 6, "R6 low side again");
        drive(0, 1, 1, 1, 0, 2, "R5 short external gap");
        drive(1, 1, 1, 1, 0, 8, "R5 short gap stretched");
        drive(1, 1, 1, 0, 0, 5, "R9 floating supply low blocks high side");
        drive(0, 0, 1, 0, 0, 8, "R9 low side unaffected by floating supply");
        drive(1, 1, 1, 1, 0, 8, "R5 back to high side");
        drive(1, 1, 1, 1, 1, 14, "R10 transient hold-off");
        drive(1, 1, 1, 1, 1, 5, "R11 first pulse");
        drive(1, 1, 1, 1, 1, 14, "R11 retrigger restarts count");
        drive(0, 0, 1, 1, 1, 14, "R10 low side unaffected by hold-off");
        drive(0, 0, 0, 1, 0, 4, "R8 logic supply low forces both off");
        drive(0, 0, 1, 1, 0, 4, "R8 recovery of low side");
        drive(1, 1, 0, 1, 0, 3, "R8 high side blocked by logic supply");
        drive(1, 1, 1, 1, 0, 8, "R1 high side after recovery");
        drive(0, 1, 1, 1, 0, 4, "R1 high side off");

        repeat (4) @(posedge clk);
        #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule